// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller for a successive-approximation converter. A prescaler divides the bus clock into a conversion clock. A sampling phase is timed in conversion-clock cycles, with its length taken from a fixed nonlinear table. After sampling, a conversion phase waits for the converter to report completion. A group of conversions forms a sequence. The channel index for each conversion is either held or stepped upward with wrap-around.

Software writes two registers. The timing register carries the prescaler value and the sample-time code. The go register carries the scan, multi-channel, external-trigger-enable, channel and sequence-length fields. Every go write abandons whatever is in flight. With external triggering off, that write starts a fresh sequence. With it on, the write arms the block, and each rising edge on the trigger input then starts one sequence. The converter side sees a sampling strobe, a converting strobe and the channel index, and it answers with a done flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion clock period is 2*(PRS+1) bus cycles. Each sampling phase holds `smp_act` high for exactly 2*(PRS+1)*N consecutive bus cycles, where N is the tick count chosen by the sample code.
- R2: Sample code 0..7 selects N = 4, 6, 8, 10, 12, 16, 20, 24 conversion-clock ticks respectively.
- R3: A go write with `go_ext`=0 abandons any activity and raises `smp_act` in the next cycle with `chan_idx` equal to `go_chan`. It wins over a same-cycle `cnv_done` or trigger, and no `seq_done` results from the abandoned sequence.
- R4: A go write with `go_ext`=1 leaves the block armed and inactive. While armed and idle, a rising edge on `ext_trig` starts a sequence, with `smp_act` high in the next cycle. Trigger edges are ignored when the block is not armed or while a sequence runs. After each sequence the block returns to waiting for a trigger, whatever `go_scan` says.
- R5: With scan and external triggering off, one sequence runs and the block then stays idle until the next go write.
- R6: With scan on and external triggering off, a new sequence begins in the cycle after `seq_done` rises, restarting from the channel written by the go write.
- R7: With `go_multi`=1 the channel index rises by one after each conversion and wraps from 15 to 0. With `go_multi`=0 it stays at `go_chan` for the whole sequence.
- R8: A length field L (0..7) gives L+1 conversions per sequence. `seq_done` is high for exactly one cycle: the cycle after the edge at which the final `cnv_done` is accepted.
- R9: The prescaler and sample code are captured when a sequence starts and hold for all of its conversions. A timing-register write in the same cycle as the start is the value captured.
- R10: After reset the block is idle and unarmed, all strobes are low, the channel index is 0, and the timing register holds PRS=5 and sample code 0.
- R11: `cnv_act` is high from the end of sampling until a cycle in which `cnv_done` is high. `cnv_done` outside the conversion phase has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_prs | input | 5 | Prescaler value |
| cfg_smp | input | 3 | Sample-time code |
| go_we | input | 1 | Go register write strobe (abort and restart or arm) |
| go_scan | input | 1 | Repeat sequences continuously |
| go_multi | input | 1 | Step the channel after each conversion |
| go_ext | input | 1 | Start sequences from trigger edges |
| go_chan | input | 4 | First channel of the sequence |
| go_len | input | 3 | Conversions per sequence minus one |
| ext_trig | input | 1 | External trigger, rising edge active |
| cnv_done | input | 1 | Converter reports the end of a conversion |
| smp_act | output | 1 | Sampling phase active |
| cnv_act | output | 1 | Conversion phase active |
| chan_idx | output | 4 | Channel being sampled or converted |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The risky overlap is a go write landing in the same cycle as the final `cnv_done` of a sequence. Here the abort and the sequence-completion logic both want to move the state. The bench turns off its automatic converter responder, waits for the conversion phase, and then drives `cnv_done` and `go_we` together. It judges that sampling restarts on the newly written channel and that `seq_done` stays low in the two following cycles. A trigger edge arriving while a sequence runs is the second overlap; the cycle-by-cycle reference model checks that it is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SMP_W  = 3;
  localparam int TICK_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_SAMPLE  = 2'd2,
    ST_CONVERT = 2'd3
  } seq_state_e;

  // Conversion-clock ticks in one sampling phase for each code.
  function automatic logic [TICK_W-1:0] smp_ticks(input logic [SMP_W-1:0] code);
    logic [TICK_W-1:0] n;
    case (code)
      3'd0:    n = 5'd4;
      3'd1:    n = 5'd6;
      3'd2:    n = 5'd8;
      3'd3:    n = 5'd10;
      3'd4:    n = 5'd12;
      3'd5:    n = 5'd16;
      3'd6:    n = 5'd20;
      default: n = 5'd24;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int PRS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRS_W-1:0] prs,
  output logic             tick
);
  localparam int CW = PRS_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;

  // Period of 2*(prs+1) bus cycles: counter runs 0 .. 2*prs+1.
  assign last_cnt = {prs, 1'b1};
  assign tick     = !restart && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart || cnt == last_cnt)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt); // R1

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [SMP_W-1:0] code,
  output logic             samp_end
);
  logic [TICK_W-1:0] tcnt;
  logic [TICK_W-1:0] need;

  assign need     = smp_ticks(code);
  assign samp_end = run && tick && (tcnt == need - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tcnt <= '0;
    else if (restart)
      tcnt <= '0;
    else if (run && tick)
      tcnt <= tcnt + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tcnt < need)); // R2

endmodule

// File: rtl/adc_chan_step.sv
module adc_chan_step #(
  parameter int CH_W  = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CH_W-1:0]  base,
  input  logic             step,
  input  logic             multi,
  input  logic [LEN_W-1:0] len,
  output logic [CH_W-1:0]  chan,
  output logic             last
);
  logic [LEN_W-1:0] done_cnt;

  assign last = (done_cnt == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan     <= '0;
      done_cnt <= '0;
    end else if (load) begin
      chan     <= base;
      done_cnt <= '0;
    end else if (step) begin
      done_cnt <= done_cnt + 1'b1;
      if (multi)
        chan <= chan + 1'b1;
    end
  end

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && multi && !load) |=> chan == CH_W'($past(chan) + 1'b1)); // R7

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !multi && !load) |=> $stable(chan)); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PRS_W   = 5,
  parameter int CH_W    = 4,
  parameter int LEN_W   = 3,
  parameter int RST_PRS = 5,
  parameter int RST_SMP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PRS_W-1:0] cfg_prs,
  input  logic [SMP_W-1:0] cfg_smp,
  input  logic             go_we,
  input  logic             go_scan,
  input  logic             go_multi,
  input  logic             go_ext,
  input  logic [CH_W-1:0]  go_chan,
  input  logic [LEN_W-1:0] go_len,
  input  logic             ext_trig,
  input  logic             cnv_done,
  output logic             smp_act,
  output logic             cnv_act,
  output logic [CH_W-1:0]  chan_idx,
  output logic             seq_done
);
  localparam logic [PRS_W-1:0] PRS_INIT = PRS_W'(RST_PRS);
  localparam logic [SMP_W-1:0] SMP_INIT = SMP_W'(RST_SMP);

  seq_state_e       state, nxt_state;
  logic             scan_r, multi_r, ext_r;
  logic [CH_W-1:0]  base_r;
  logic [LEN_W-1:0] len_r;
  logic [PRS_W-1:0] prs_reg, prs_lat, prs_eff;
  logic [SMP_W-1:0] smp_reg, smp_lat, smp_eff;
  logic             trig_q, done_q;

  // Named internal events
  logic             trig_evt;
  logic             new_seq;
  logic             next_conv;
  logic             seq_end;
  logic             phase_restart;
  logic             conv_step;
  logic             samp_end;
  logic             div_tick;
  logic             last_conv;
  logic             chan_load;
  logic [CH_W-1:0]  chan_base;
  logic [CH_W-1:0]  chan_cur;

  assign trig_evt      = ext_trig && !trig_q;
  assign prs_eff       = cfg_we ? cfg_prs : prs_reg;
  assign smp_eff       = cfg_we ? cfg_smp : smp_reg;
  assign phase_restart = new_seq || next_conv;
  assign chan_load     = new_seq || go_we;
  assign chan_base     = go_we ? go_chan : base_r;
  assign conv_step     = next_conv && !go_we;

  always_comb begin
    nxt_state = state;
    new_seq   = 1'b0;
    next_conv = 1'b0;
    seq_end   = 1'b0;
    if (go_we) begin
      if (go_ext) begin
        nxt_state = ST_ARMED;
      end else begin
        nxt_state = ST_SAMPLE;
        new_seq   = 1'b1;
      end
    end else begin
      case (state)
        ST_ARMED: begin
          if (trig_evt) begin
            nxt_state = ST_SAMPLE;
            new_seq   = 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (samp_end) nxt_state = ST_CONVERT;
        end
        ST_CONVERT: begin
          if (cnv_done) begin
            if (!last_conv) begin
              nxt_state = ST_SAMPLE;
              next_conv = 1'b1;
            end else begin
              seq_end = 1'b1;
              if (ext_r) begin
                nxt_state = ST_ARMED;
              end else if (scan_r) begin
                nxt_state = ST_SAMPLE;
                new_seq   = 1'b1;
              end else begin
                nxt_state = ST_IDLE;
              end
            end
          end
        end
        default: nxt_state = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      scan_r  <= 1'b0;
      multi_r <= 1'b0;
      ext_r   <= 1'b0;
      base_r  <= '0;
      len_r   <= '0;
      prs_reg <= PRS_INIT;
      smp_reg <= SMP_INIT;
      prs_lat <= PRS_INIT;
      smp_lat <= SMP_INIT;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state  <= nxt_state;
      trig_q <= ext_trig;
      done_q <= seq_end;
      if (cfg_we) begin
        prs_reg <= cfg_prs;
        smp_reg <= cfg_smp;
      end
      if (go_we) begin
        scan_r  <= go_scan;
        multi_r <= go_multi;
        ext_r   <= go_ext;
        base_r  <= go_chan;
        len_r   <= go_len;
      end
      if (new_seq) begin
        prs_lat <= prs_eff;
        smp_lat <= smp_eff;
      end
    end
  end

  adc_clkdiv #(.PRS_W(PRS_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_restart),
    .prs     (prs_lat),
    .tick    (div_tick)
  );

  adc_samp_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (phase_restart),
    .run      (state == ST_SAMPLE),
    .tick     (div_tick),
    .code     (smp_lat),
    .samp_end (samp_end)
  );

  adc_chan_step #(.CH_W(CH_W), .LEN_W(LEN_W)) u_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (chan_load),
    .base  (chan_base),
    .step  (conv_step),
    .multi (multi_r),
    .len   (len_r),
    .chan  (chan_cur),
    .last  (last_conv)
  );

  assign smp_act  = (state == ST_SAMPLE);
  assign cnv_act  = (state == ST_CONVERT);
  assign chan_idx = chan_cur;
  assign seq_done = done_q;

  AST_GO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (go_we && !go_ext) |=> (smp_act && chan_idx == $past(go_chan))); // R3

  AST_GO_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go_we |=> !seq_done); // R3

  AST_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go_we && go_ext) |=> (!smp_act && !cnv_act)); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !go_we) |=> state == ST_IDLE); // R5

  AST_SCAN_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && scan_r && !ext_r) |=> (smp_act && chan_idx == base_r)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R8

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((smp_act || cnv_act) && !new_seq) |=> ($stable(prs_lat) && $stable(smp_lat))); // R9

  AST_CNV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_act && !cnv_done && !go_we) |=> cnv_act); // R11

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_prs;
  logic [2:0] cfg_smp;
  logic       go_we, go_scan, go_multi, go_ext;
  logic [3:0] go_chan;
  logic [2:0] go_len;
  logic       ext_trig;
  logic       cnv_done;
  wire        smp_act, cnv_act, seq_done;
  wire  [3:0] chan_idx;

  always #5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prs(cfg_prs), .cfg_smp(cfg_smp),
    .go_we(go_we), .go_scan(go_scan), .go_multi(go_multi), .go_ext(go_ext),
    .go_chan(go_chan), .go_len(go_len), .ext_trig(ext_trig), .cnv_done(cnv_done),
    .smp_act(smp_act), .cnv_act(cnv_act), .chan_idx(chan_idx), .seq_done(seq_done)
  );

  int  checks = 0, fails = 0;
  int  cmp_checks = 0, cmp_fails = 0;
  bit  run_cmp = 0;
  bit  auto_en = 1;
  bit  man_done = 0;
  int  cd_cnt = 0;
  int  npulse = 0;

  // Tick count per code, restated as arithmetic
  function automatic int ticks(int c);
    return (c < 4) ? 4 + 2 * c : 12 + 4 * (c - 4);
  endfunction
  function automatic int samp_len(int p, int s);
    return 2 * (p + 1) * ticks(s);
  endfunction

  // ---------------- reference model ----------------
  int m_st, m_left, m_chan, m_base, m_cnt, m_len;
  int m_prs, m_smp, m_lprs, m_lsmp;
  bit m_scan, m_multi, m_ext, m_tq, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_chan = 0; m_base = 0; m_cnt = 0; m_len = 0;
      m_prs = 5; m_smp = 0; m_lprs = 5; m_lsmp = 0;
      m_scan = 0; m_multi = 0; m_ext = 0; m_tq = 0; m_done = 0;
    end else begin
      automatic int  ep = cfg_we ? int'(cfg_prs) : m_prs;
      automatic int  es = cfg_we ? int'(cfg_smp) : m_smp;
      automatic bit  evt = ext_trig && !m_tq;
      automatic bit  begin_seq = 0;
      m_done = 0;
      if (go_we) begin
        m_scan = go_scan; m_multi = go_multi; m_ext = go_ext;
        m_base = go_chan; m_len = go_len; m_chan = go_chan; m_cnt = 0;
        if (go_ext) m_st = 1; else begin_seq = 1;
      end else begin
        case (m_st)
          1: if (evt) begin_seq = 1;
          2: if (m_left == 1) m_st = 3; else m_left--;
          3: if (cnv_done) begin
               if (m_cnt != m_len) begin
                 m_cnt++;
                 if (m_multi) m_chan = (m_chan + 1) % 16;
                 m_st = 2;
                 m_left = samp_len(m_lprs, m_lsmp);
               end else begin
                 m_done = 1;
                 if (m_ext) m_st = 1;
                 else if (m_scan) begin_seq = 1;
                 else m_st = 0;
               end
             end
          default: ;
        endcase
      end
      if (begin_seq) begin
        m_chan = m_base; m_cnt = 0; m_lprs = ep; m_lsmp = es;
        m_left = samp_len(ep, es); m_st = 2;
      end
      if (cfg_we) begin m_prs = cfg_prs; m_smp = cfg_smp; end
      m_tq = ext_trig;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      cmp_checks += 4;
      if (smp_act !== (m_st == 2)) begin cmp_fails++;
        $display("FAIL R1/R2 smp_act actual=%0d expected=%0d t=%0t", smp_act, m_st == 2, $time); end
      if (cnv_act !== (m_st == 3)) begin cmp_fails++;
        $display("FAIL R11 cnv_act actual=%0d expected=%0d t=%0t", cnv_act, m_st == 3, $time); end
      if (int'(chan_idx) != m_chan) begin cmp_fails++;
        $display("FAIL R7 chan_idx actual=%0d expected=%0d t=%0t", chan_idx, m_chan, $time); end
      if (seq_done !== m_done) begin cmp_fails++;
        $display("FAIL R8 seq_done actual=%0d expected=%0d t=%0t", seq_done, m_done, $time); end
    end
  end

  // ---------------- converter responder ----------------
  always @(negedge clk) begin
    cnv_done = (auto_en && cnv_act && cd_cnt == 3) || man_done;
    if (cnv_done && cnv_act) npulse++;
    cd_cnt = cnv_act ? cd_cnt + 1 : 0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go(input bit sc, input bit mu, input bit ex, input int ch, input int ln);
    go_we = 1; go_scan = sc; go_multi = mu; go_ext = ex;
    go_chan = 4'(ch); go_len = 3'(ln);
    @(negedge clk);
    go_we = 0;
  endtask

  task automatic cfg(input int p, input int s);
    cfg_we = 1; cfg_prs = 5'(p); cfg_smp = 3'(s);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (smp_act && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_done();
    int k = 0;
    while (!seq_done && k < 5000) begin k++; @(negedge clk); end
    chk("R8", "seq_done reached", int'(seq_done), 1);
  endtask

  task automatic wait_cnv();
    int k = 0;
    while (!cnv_act && k < 2000) begin k++; @(negedge clk); end
  endtask

  task automatic trig_pulse();
    ext_trig = 1;
    @(negedge clk);
    ext_trig = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + cmp_checks + 1, fails + cmp_fails + 1);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int n, p0;
    rst_n = 0; cfg_we = 0; cfg_prs = 0; cfg_smp = 0;
    go_we = 0; go_scan = 0; go_multi = 0; go_ext = 0; go_chan = 0; go_len = 0;
    ext_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run_cmp = 1;
    // R10: reset state
    chk("R10", "smp_act after reset", int'(smp_act), 0);
    chk("R10", "cnv_act after reset", int'(cnv_act), 0);
    chk("R10", "chan_idx after reset", int'(chan_idx), 0);
    chk("R10", "seq_done after reset", int'(seq_done), 0);

    // R10 R1: reset timing values give PRS=5 code 0
    go(0, 0, 0, 3, 0);
    measure(n);
    chk("R10", "default sample length", n, samp_len(5, 0));
    wait_done();
    repeat (2) @(negedge clk);
    chk("R5", "idle after single sequence smp", int'(smp_act), 0);
    chk("R5", "idle after single sequence cnv", int'(cnv_act), 0);

    // R2: every sample code at PRS=0
    for (int s = 0; s < 8; s++) begin
      cfg(0, s);
      go(0, 0, 0, 0, 0);
      measure(n);
      chk("R2", $sformatf("sample length code %0d", s), n, samp_len(0, s));
      wait_done();
    end
    // R1: larger prescaler
    cfg(2, 5);
    go(0, 0, 0, 0, 0);
    measure(n);
    chk("R1", "sample length prs2 code5", n, samp_len(2, 5));
    wait_done();

    // R7 R8: multi-channel with wrap, four conversions
    cfg(0, 0);
    p0 = npulse;
    go(0, 1, 0, 14, 3);
    wait_done();
    chk("R8", "conversions in len3 sequence", npulse - p0, 4);
    chk("R7", "channel after wrap", int'(chan_idx), 1);

    // R7: fixed channel
    p0 = npulse;
    go(0, 0, 0, 9, 2);
    wait_done();
    chk("R8", "conversions in len2 sequence", npulse - p0, 3);
    chk("R7", "channel held", int'(chan_idx), 9);

    // R6: scan restart
    go(1, 0, 0, 5, 0);
    wait_done();
    @(negedge clk);
    chk("R6", "scan restarts sampling", int'(smp_act), 1);
    chk("R6", "scan restarts on base channel", int'(chan_idx), 5);
    go(0, 0, 0, 0, 0);
    wait_done();

    // R3: abort during sampling
    go(0, 0, 0, 11, 0);
    repeat (3) @(negedge clk);
    go(0, 0, 0, 2, 0);
    chk("R3", "abort resamples", int'(smp_act), 1);
    chk("R3", "abort loads channel", int'(chan_idx), 2);
    measure(n);
    chk("R3", "abort gives full sample", n, samp_len(0, 0));
    wait_done();

    // R3: go write coinciding with final cnv_done
    auto_en = 0;
    go(0, 0, 0, 4, 0);
    wait_cnv();
    man_done = 1;
    go_we = 1; go_scan = 0; go_multi = 0; go_ext = 0; go_chan = 4'd7; go_len = 3'd0;
    @(negedge clk);
    man_done = 0; go_we = 0;
    chk("R3", "coincident write resamples", int'(smp_act), 1);
    chk("R3", "coincident write channel", int'(chan_idx), 7);
    chk("R3", "coincident write no seq_done", int'(seq_done), 0);
    @(negedge clk);
    chk("R3", "coincident write no late seq_done", int'(seq_done), 0);
    auto_en = 1;
    wait_done();

    // R11: cnv_done during sampling ignored
    go(0, 0, 0, 1, 0);
    man_done = 1;
    @(negedge clk);
    man_done = 0;
    measure(n);
    chk("R11", "sample length with stray done", n + 1, samp_len(0, 0));
    wait_done();

    // R11 R8: convert phase holds until done, single-cycle pulse
    auto_en = 0;
    go(0, 0, 0, 0, 0);
    wait_cnv();
    repeat (20) @(negedge clk);
    chk("R11", "convert held without done", int'(cnv_act), 1);
    man_done = 1;
    @(negedge clk);
    man_done = 0;
    chk("R8", "seq_done one cycle after done", int'(seq_done), 1);
    @(negedge clk);
    chk("R8", "seq_done drops", int'(seq_done), 0);
    auto_en = 1;

    // R4: external triggering
    trig_pulse();
    @(negedge clk);
    chk("R4", "unarmed trigger ignored", int'(smp_act), 0);
    go(0, 0, 1, 6, 0);
    chk("R4", "arming write stays quiet", int'(smp_act | cnv_act), 0);
    repeat (5) @(negedge clk);
    chk("R4", "armed waits", int'(smp_act), 0);
    trig_pulse();
    chk("R4", "trigger starts sampling", int'(smp_act), 1);
    repeat (2) @(negedge clk);
    trig_pulse();
    wait_done();
    repeat (2) @(negedge clk);
    chk("R4", "back to waiting after sequence", int'(smp_act | cnv_act), 0);
    go(1, 0, 1, 8, 1);
    trig_pulse();
    chk("R4", "scan with trigger starts", int'(smp_act), 1);
    wait_done();
    repeat (3) @(negedge clk);
    chk("R4", "scan with trigger waits again", int'(smp_act | cnv_act), 0);
    trig_pulse();
    chk("R4", "second trigger starts", int'(smp_act), 1);
    go(0, 0, 0, 0, 0);
    wait_done();

    // R9: timing values captured per sequence
    go(0, 0, 0, 0, 1);
    cfg(3, 0);
    measure(n);
    chk("R9", "first conversion unchanged", n + 1, samp_len(0, 0));
    begin
      int k = 0;
      while (!smp_act && k < 500) begin k++; @(negedge clk); end
    end
    measure(n);
    chk("R9", "second conversion unchanged", n, samp_len(0, 0));
    wait_done();
    go(0, 0, 0, 0, 0);
    measure(n);
    chk("R9", "next sequence uses new value", n, samp_len(3, 0));
    wait_done();
    cfg_we = 1; cfg_prs = 5'd1; cfg_smp = 3'd1;
    go(0, 0, 0, 0, 0);
    cfg_we = 0;
    measure(n);
    chk("R9", "same-cycle timing write captured", n, samp_len(1, 1));
    wait_done();

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks + cmp_checks, fails + cmp_fails);
    $finish;
  end

endmodule